// File: doc/BRIEF.md
# Sub-word memory access aligner

This block sits between a processor core and a data memory that is one 32-bit word wide. It handles accesses narrower than a word in both directions. On the store side it places a byte or halfword of the source register into the correct byte lanes of the outgoing word and raises only the matching bits of a per-lane write mask. On the load side it selects a byte or halfword out of the returned memory word and sign-extends it to the full register width.

The access width comes from the instruction's three-bit funct3 field. The lane comes from the low bits of the effective address, which the core's adder has already computed. Both paths are purely combinational and have separate inputs. A store from one instruction and a load from another can therefore be presented in the same cycle. Every port is a plain level signal with no handshake, because the block adds no latency and holds no data.

Top module: `mem_lane_aligner`

## Requirements
- R1: The width code is decoded from funct3 as follows: 0 selects a byte, 1 selects a halfword, 2 selects a word, and every other value is treated as a word. The same decoding applies to stores and loads.
- R2: A byte store with the store enable high sets exactly one mask bit, at position addr[1:0]. Mask bit n guards data bits 8n+7 down to 8n.
- R3: A halfword store sets mask 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. Address bit 0 has no effect on it.
- R4: A word store sets mask 4'b1111 at every address offset.
- R5: Store write data depends on the width. For a byte, source bits [7:0] are repeated in all four lanes. For a halfword, source bits [15:0] are repeated in both halves. For a word, the source is passed through unchanged.
- R6: While the store enable is low, the mask is 4'b0000 for every width and offset.
- R7: A byte load returns the byte in lane addr[1:0], sign-extended from its bit 7.
- R8: A halfword load returns bits [15:0] when addr[1] is 0 and bits [31:16] when addr[1] is 1, sign-extended from its bit 15. Address bit 0 has no effect on it.
- R9: A word load returns the memory word unchanged at every offset.
- R10: The store and load paths are independent. Any store input presented in the same cycle as any load input leaves each result as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_en | input | 1 | Store enable; when low the write mask is forced to zero |
| st_addr_lo | input | 2 | Low bits of the store effective address |
| st_funct3 | input | 3 | Store width code |
| st_src | input | 32 | Source register value to be stored |
| st_wdata | output | 32 | Lane-aligned write data for memory |
| st_mask | output | 4 | Per-byte-lane write enables |
| ld_addr_lo | input | 2 | Low bits of the load effective address |
| ld_funct3 | input | 3 | Load width code |
| ld_word | input | 32 | Word returned by memory |
| ld_result | output | 32 | Extracted, sign-extended register value |

## Verification
The two functions that share a cycle are store packing and load extraction. In the block's real use, one instruction's store and another's load can be in flight together. Every row of the vector table drives a store and a load at once, with different widths, offsets and sign bits. A sweep then pairs every store width, offset and enable state with a load of another width at the opposite offset. Each output is compared against a bench model that sees only its own path's inputs, so any leakage between the paths shows up as a mismatch.

// File: rtl/mla_pkg.sv
package mla_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // Width decode shared by both paths (R1)
  function automatic acc_size_e decode_size(input logic [2:0] f3);
    case (f3)
      3'd0:    return SZ_BYTE;
      3'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/mla_store_pack.sv
module mla_store_pack #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic              en,
  input  logic [LB-1:0]     addr,
  input  logic [2:0]        funct3,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  mask
);
  import mla_pkg::*;

  acc_size_e  sz;
  logic [1:0] szb;

  assign sz  = decode_size(funct3);
  assign szb = sz;

  // A lane is selected when it shares the access-aligned block with addr
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(i);
    assign mask[i] = en && ((IDX >> szb) == (addr >> szb));
    assign wdata[8*i +: 8] = (sz == SZ_BYTE) ? src[7:0] :
                             (sz == SZ_HALF) ? src[8*(i%2) +: 8] :
                                               src[8*i +: 8];
  end

  always_comb begin
    if (!en) begin
      AST_MASK_IDLE: assert (mask == '0) else $error("mask active while idle"); // R6
    end else begin
      AST_MASK_WIDTH: assert ($countones(mask) == (32'd1 << szb)) else $error("mask width"); // R1
      AST_MASK_HITS_ADDR: assert (mask[addr]) else $error("addressed lane not enabled"); // R2
      AST_DATA_IN_LANE: assert (wdata[8*addr +: 8] == src[8*(addr & ((LB'(1) << szb) - LB'(1))) +: 8])
        else $error("addressed lane data"); // R5
    end
  end

endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic [LB-1:0]     addr,
  input  logic [2:0]        funct3,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  import mla_pkg::*;

  acc_size_e         sz;
  logic [1:0]        szb;
  logic [LB-1:0]     off;
  logic [DATA_W-1:0] shifted;

  assign sz      = decode_size(funct3);
  assign szb     = sz;
  assign off     = (addr >> szb) << szb;
  assign shifted = word >> {off, 3'b000};

  always_comb begin
    case (sz)
      SZ_BYTE: result = {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
      default: result = word;
    endcase
  end

  always_comb begin
    if (sz == SZ_BYTE) begin
      AST_BYTE_SIGN: assert (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}) else $error("byte sign fill"); // R7
      AST_BYTE_SRC: assert (result[7:0] == word[8*addr +: 8]) else $error("byte lane"); // R7
    end
    if (sz == SZ_HALF) begin
      AST_HALF_SIGN: assert (result[DATA_W-1:16] == {(DATA_W-16){result[15]}}) else $error("half sign fill"); // R8
    end
  end

endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic              st_en,
  input  logic [LB-1:0]     st_addr_lo,
  input  logic [2:0]        st_funct3,
  input  logic [DATA_W-1:0] st_src,
  output logic [DATA_W-1:0] st_wdata,
  output logic [LANES-1:0]  st_mask,
  input  logic [LB-1:0]     ld_addr_lo,
  input  logic [2:0]        ld_funct3,
  input  logic [DATA_W-1:0] ld_word,
  output logic [DATA_W-1:0] ld_result
);

  // Store and load paths share no signals (R10)
  mla_store_pack #(.DATA_W(DATA_W)) u_store (
    .en     (st_en),
    .addr   (st_addr_lo),
    .funct3 (st_funct3),
    .src    (st_src),
    .wdata  (st_wdata),
    .mask   (st_mask)
  );

  mla_load_extract #(.DATA_W(DATA_W)) u_load (
    .addr   (ld_addr_lo),
    .funct3 (ld_funct3),
    .word   (ld_word),
    .result (ld_result)
  );

endmodule

// File: tb/sim_mem_lane_aligner.sv
module sim_mem_lane_aligner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_en;
  logic [1:0]  st_addr_lo, ld_addr_lo;
  logic [2:0]  st_funct3, ld_funct3;
  logic [31:0] st_src, st_wdata, ld_word, ld_result;
  logic [3:0]  st_mask;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mem_lane_aligner u0 (
    .st_en(st_en), .st_addr_lo(st_addr_lo), .st_funct3(st_funct3), .st_src(st_src),
    .st_wdata(st_wdata), .st_mask(st_mask),
    .ld_addr_lo(ld_addr_lo), .ld_funct3(ld_funct3), .ld_word(ld_word), .ld_result(ld_result)
  );

  typedef struct packed {
    logic [2:0]  s_f3;
    logic [1:0]  s_ad;
    logic [31:0] s_src;
    logic        s_en;
    logic [3:0]  e_mask;
    logic [31:0] e_wdata;
    logic [2:0]  l_f3;
    logic [1:0]  l_ad;
    logic [31:0] l_word;
    logic [31:0] e_res;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    {3'd0, 2'd1, 32'h12345678, 1'b1, 4'b0010, 32'h78787878, 3'd0, 2'd1, 32'h11228344, 32'hFFFFFF83},
    {3'd1, 2'd2, 32'hAAAA8001, 1'b1, 4'b1100, 32'h80018001, 3'd1, 2'd2, 32'h7FFE0000, 32'h00007FFE},
    {3'd2, 2'd3, 32'hDEADBEEF, 1'b1, 4'b1111, 32'hDEADBEEF, 3'd2, 2'd1, 32'hCAFEF00D, 32'hCAFEF00D},
    {3'd1, 2'd3, 32'h0000ABCD, 1'b1, 4'b1100, 32'hABCDABCD, 3'd1, 2'd1, 32'h1234F00D, 32'hFFFFF00D},
    {3'd0, 2'd0, 32'h000000FF, 1'b0, 4'b0000, 32'hFFFFFFFF, 3'd0, 2'd3, 32'h7F000000, 32'h0000007F},
    {3'd3, 2'd2, 32'h01020304, 1'b1, 4'b1111, 32'h01020304, 3'd0, 2'd2, 32'h00800000, 32'hFFFFFF80}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_mask(input logic [2:0] f3, input logic [1:0] a, input logic en);
    if (!en) return 4'b0000;
    case (f3)
      3'd0:    return 4'b0001 << a;
      3'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_wdata(input logic [2:0] f3, input logic [31:0] s);
    case (f3)
      3'd0:    return {4{s[7:0]}};
      3'd1:    return {2{s[15:0]}};
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] m_load(input logic [2:0] f3, input logic [1:0] a, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    case (a)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = a[1] ? w[31:16] : w[15:0];
    case (f3)
      3'd0:    return {{24{b[7]}}, b};
      3'd1:    return {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f3, input bit is_load);
    if (is_load) return (f3 == 3'd0) ? "R7 byte load" : (f3 == 3'd1) ? "R8 half load" : "R9 word load";
    return (f3 == 3'd0) ? "R2 byte mask" : (f3 == 3'd1) ? "R3 half mask" : "R4 word mask";
  endfunction

  initial begin
    st_en = 1'b0; st_addr_lo = '0; st_funct3 = '0; st_src = '0;
    ld_addr_lo = '0; ld_funct3 = '0; ld_word = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset-time state with idle inputs (R6, R7)
    chk("R6 idle mask", {28'd0, st_mask}, 32'd0);
    chk("R7 idle result", ld_result, 32'd0);

    // Vector table: store and load driven together (R10)
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      st_funct3 = VEC[i].s_f3; st_addr_lo = VEC[i].s_ad; st_src = VEC[i].s_src; st_en = VEC[i].s_en;
      ld_funct3 = VEC[i].l_f3; ld_addr_lo = VEC[i].l_ad; ld_word = VEC[i].l_word;
      @(negedge clk);
      chk("R10 R1 table mask", {28'd0, st_mask}, {28'd0, VEC[i].e_mask});
      chk("R10 R5 table wdata", st_wdata, VEC[i].e_wdata);
      chk("R10 table load", ld_result, VEC[i].e_res);
    end

    // Sweep every width, offset and enable, with concurrent loads (R10)
    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < 4; a++) begin
        for (int e = 0; e < 2; e++) begin
          for (int p = 0; p < 2; p++) begin
            @(posedge clk);
            st_funct3 = 3'(f); st_addr_lo = 2'(a); st_en = e[0];
            st_src = p[0] ? 32'h9ABC_DEF0 : 32'h1357_2468;
            ld_funct3 = 3'((f + 1) % 3); ld_addr_lo = 2'(3 - a);
            ld_word = p[0] ? 32'h8070_F00F : 32'h7F80_01FE;
            @(negedge clk);
            if (e == 0) chk("R6 mask off", {28'd0, st_mask}, 32'd0);
            else chk(tag_of(3'(f), 1'b0), {28'd0, st_mask}, {28'd0, m_mask(3'(f), 2'(a), 1'b1)});
            chk("R5 store data", st_wdata, m_wdata(3'(f), st_src));
            chk(tag_of(ld_funct3, 1'b1), ld_result, m_load(ld_funct3, ld_addr_lo, ld_word));
          end
        end
      end
    end

    // Directed corner cases: ignored low address bit and upper funct3 codes (R3, R8, R1)
    @(posedge clk);
    st_en = 1'b1; st_funct3 = 3'd1; st_addr_lo = 2'd1; st_src = 32'h0000_5A5A;
    ld_funct3 = 3'd1; ld_addr_lo = 2'd3; ld_word = 32'hC001_0000;
    @(negedge clk);
    chk("R3 half addr0 ignored", {28'd0, st_mask}, 32'h3);
    chk("R8 half addr0 ignored", ld_result, 32'hFFFF_C001);
    @(posedge clk);
    st_funct3 = 3'd7; st_addr_lo = 2'd1; st_src = 32'hA1B2_C3D4;
    ld_funct3 = 3'd5; ld_addr_lo = 2'd2; ld_word = 32'h8000_0001;
    @(negedge clk);
    chk("R1 code7 as word mask", {28'd0, st_mask}, 32'hF);
    chk("R1 code7 as word data", st_wdata, 32'hA1B2_C3D4);
    chk("R1 code5 as word load", ld_result, 32'h8000_0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule